// File: doc/BRIEF.md
# Multi-Bit LFSR Sequence Source

This block generates a maximal-length style binary sequence from a linear feedback shift register of degree K. Each clock it moves on by M positions of the sequence, not by one, and it presents M consecutive samples side by side. Scramblers and descramblers that handle several bits per symbol can use it to get one word per symbol without a serial pre-fill buffer.

The K-bit state holds a window of the sequence. Bit i of the state is sample c(n+i). Every advancing cycle the state passes through a fixed GF(2) network equal to the single-step companion matrix raised to the power M. A second fixed network maps the new state to the M output samples. Both networks are worked out while the design elaborates, from a polynomial parameter, so only XOR trees remain in hardware. A seed strobe replaces the state, and an enable selects between moving on and holding.

Top module: `lfsr_par_gen`

## Requirements
- R1: A synchronous active-high reset sets the state to RST_SEED. On the clock after reset, dout holds the first M samples of the sequence that starts at that state.
- R2: With adv high and seed_ld low, each clock advances the sequence by exactly M samples. dout then holds the next M samples with no gap and no overlap.
- R3: dout bit 0 carries the earliest sample and bit M-1 the latest. When M is at most K, dout equals the low M bits of the state, so right after a load dout equals seed[M-1:0].
- R4: seed_ld has priority over adv in the same cycle. The seed becomes the state at that clock edge, and dout shows the samples that start at the seed on the next cycle.
- R5: While seed_ld and adv are both low, the state holds and dout stays unchanged.
- R6: The block works for M larger than K. dout still equals M consecutive samples of the serial recurrence.
- R7: A seed load with an all-zero seed is not allowed.
- R8: POLY bit k is the coefficient a_k, and the sequence obeys c(n+K) = XOR of a_k·c(n+k) over k < K. Seed bit i is sample c(n+i).
- R9: Starting from a nonzero seed or reset value, with a_0 = 1, the state never becomes all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_ld | input | 1 | Load seed into the state (priority over adv) |
| seed | input | K | New state; bit i is sample c(n+i) |
| adv | input | 1 | Advance the sequence by M samples |
| dout | output | M | Registered samples; bit 0 earliest |

## Verification
The hardest case to reach from the ports is a seed load in the same cycle as an advance. It must not run on by M after it takes effect. The same holds for the word that follows straight after it. The bench drives this collision on purpose and then sprinkles it through a random run, comparing against a serial one-step model that is stepped M times per cycle. Three instances run in parallel: M smaller than K, M larger than K, and M of one. These let the jump network's rows for long shifts, and the edge where output rows stop being plain bit selections, show any error.

// File: rtl/lfsr_par_pkg.sv
package lfsr_par_pkg;

  localparam int MAXK = 64;

  // Mask over the K state bits that produces sample c(n+d), computed by
  // running the recurrence symbolically d times.
  function automatic logic [MAXK-1:0] shift_mask(input logic [MAXK-1:0] poly,
                                                 input int k, input int d);
    logic [MAXK-1:0] win [MAXK];
    logic [MAXK-1:0] fb;
    for (int i = 0; i < MAXK; i++) win[i] = (i < k) ? (64'd1 << i) : '0;
    for (int t = 0; t < d; t++) begin
      fb = '0;
      for (int i = 0; i < k; i++) if (poly[i]) fb ^= win[i];
      for (int i = 0; i < k - 1; i++) win[i] = win[i+1];
      win[k-1] = fb;
    end
    return win[0];
  endfunction

endpackage

// File: rtl/lfsr_mask_net.sv
module lfsr_mask_net #(
  parameter int K = 25,
  parameter int ROWS = 6,
  parameter int BASE = 0,
  parameter logic [K-1:0] POLY = 25'h0000009
) (
  input  logic [K-1:0]    st,
  output logic [ROWS-1:0] bits
);
  import lfsr_par_pkg::*;

  // Row r produces sample c(n + BASE + r) as an XOR over selected state bits
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam logic [MAXK-1:0] MK = shift_mask(64'(POLY), K, BASE + r);
    assign bits[r] = ^(st & MK[K-1:0]);
  end
endmodule

// File: rtl/lfsr_par_chk.sv
module lfsr_par_chk #(
  parameter int K = 25,
  parameter int M = 6,
  parameter logic [K-1:0] RST_SEED = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         seed_ld,
  input logic [K-1:0] seed,
  input logic         adv,
  input logic [M-1:0] dout,
  input logic [K-1:0] state
);
  p_no_zero_seed_r7: assert property (@(posedge clk) disable iff (rst)
    seed_ld |-> seed != '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!seed_ld && !adv) |=> $stable(dout));

  p_state_live_r9: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  if (M <= K) begin : g_sel
    p_load_sel_r3: assert property (@(posedge clk) disable iff (rst)
      seed_ld |=> dout == $past(seed[M-1:0]));
    p_reset_word_r1: assert property (@(posedge clk)
      $past(rst) |-> dout == RST_SEED[M-1:0]);
  end

  if (M < K) begin : g_shift
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
      (!seed_ld && adv) |=> dout[0] == $past(state[M]));
  end
endmodule

bind lfsr_par_gen lfsr_par_chk #(.K(K), .M(M), .RST_SEED(RST_SEED)) u_chk (
  .clk(clk), .rst(rst), .seed_ld(seed_ld), .seed(seed),
  .adv(adv), .dout(dout), .state(state_q)
);

// File: rtl/lfsr_par_gen.sv
module lfsr_par_gen #(
  parameter int K = 25,
  parameter int M = 6,
  parameter logic [K-1:0] POLY = 25'h0000009,
  parameter logic [K-1:0] RST_SEED = 25'h0000001
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_ld,
  input  logic [K-1:0] seed,
  input  logic         adv,
  output logic [M-1:0] dout
);
  logic [K-1:0] state_q;
  logic [K-1:0] state_d;
  logic [K-1:0] jump;
  logic [M-1:0] word_d;

  // Next state after M steps: rows of the companion matrix to the power M
  lfsr_mask_net #(.K(K), .ROWS(K), .BASE(M), .POLY(POLY)) u_jump (
    .st(state_q), .bits(jump)
  );

  // Reset, then load, then advance, otherwise hold
  always_comb begin
    if (rst)          state_d = RST_SEED;
    else if (seed_ld) state_d = seed;
    else if (adv)     state_d = jump;
    else              state_d = state_q;
  end

  // Output rows: samples 0..M-1 of the window held in the next state
  lfsr_mask_net #(.K(K), .ROWS(M), .BASE(0), .POLY(POLY)) u_out (
    .st(state_d), .bits(word_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
    dout    <= word_d;
  end
endmodule

// File: tb/tb_lfsr_par_gen.sv
module tb_lfsr_par_gen;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld = 1'b0;
  logic adv = 1'b0;
  logic [24:0] sd = 25'h1;
  logic [6:0] sd7;
  logic [5:0]  d_a;
  logic [11:0] d_b;
  logic [0:0]  d_c;

  always #(PERIOD/2) clk = ~clk;
  assign sd7 = (sd[6:0] == 7'd0) ? 7'h05 : sd[6:0];

  // M < K, polynomial x^25 + x^3 + 1
  lfsr_par_gen #(.K(25), .M(6), .POLY(25'h0000009), .RST_SEED(25'h1)) dut (
    .clk(clk), .rst(rst), .seed_ld(ld), .seed(sd), .adv(adv), .dout(d_a));
  // M > K, polynomial x^7 + x + 1
  lfsr_par_gen #(.K(7), .M(12), .POLY(7'h03), .RST_SEED(7'h01)) dut_w (
    .clk(clk), .rst(rst), .seed_ld(ld), .seed(sd7), .adv(adv), .dout(d_b));
  // M = 1, polynomial x^25 + x^3 + x^2 + x + 1
  lfsr_par_gen #(.K(25), .M(1), .POLY(25'h000000F), .RST_SEED(25'h1)) dut_1 (
    .clk(clk), .rst(rst), .seed_ld(ld), .seed(sd), .adv(adv), .dout(d_c));

  typedef struct {
    logic [31:0] ea;
    logic [31:0] eb;
    logic [31:0] ec;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] ra, rb, rc;

  function automatic logic [31:0] ser_step(logic [31:0] s, logic [31:0] p, int k);
    logic fb;
    fb = ^(s & p);
    s = s >> 1;
    s[k-1] = fb;
    return s;
  endfunction

  function automatic logic [31:0] ser_word(logic [31:0] s, logic [31:0] p, int k, int m);
    logic [31:0] w = '0;
    for (int j = 0; j < m; j++) begin
      w[j] = s[0];
      s = ser_step(s, p, k);
    end
    return w;
  endfunction

  function automatic logic [31:0] ser_jump(logic [31:0] s, logic [31:0] p, int k, int m);
    for (int j = 0; j < m; j++) s = ser_step(s, p, k);
    return s;
  endfunction

  // Driver: sets inputs for the next edge and queues the expected words
  task automatic apply(input logic r, input logic l, input logic a,
                       input logic [24:0] s, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; ld = l; adv = a; sd = s;
    #1;
    if (r) begin
      ra = 32'h1; rb = 32'h1; rc = 32'h1;
    end else if (l) begin
      ra = {7'd0, s}; rb = {25'd0, sd7}; rc = {7'd0, s};
    end else if (a) begin
      ra = ser_jump(ra, 32'h9, 25, 6);
      rb = ser_jump(rb, 32'h3, 7, 12);
      rc = ser_jump(rc, 32'hF, 25, 1);
    end
    e.ea = ser_word(ra, 32'h9, 25, 6);
    e.eb = ser_word(rb, 32'h3, 7, 12);
    e.ec = ser_word(rc, 32'hF, 25, 1);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic cmp(input string tag, input string nm, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", tag, nm, got, exp);
    end
  endtask

  // Monitor: samples one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, "dut",   {26'd0, d_a}, e.ea);
      cmp(e.tag, "dut_w", {20'd0, d_b}, e.eb);
      cmp(e.tag, "dut_1", {31'd0, d_c}, e.ec);
    end
  end

  function automatic logic [24:0] rnd_seed();
    logic [24:0] v;
    v = 25'($urandom);
    return (v == 25'd0) ? 25'h1ACE1 : v;
  endfunction

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    apply(1, 0, 0, 25'h1, "R1");
    apply(1, 0, 1, 25'h1, "R1");
    for (int i = 0; i < 3; i++) apply(0, 0, 0, 25'h1, "R5");
    for (int i = 0; i < 20; i++) apply(0, 0, 1, 25'h1, "R2");
    // collision: load and advance together
    apply(0, 1, 1, 25'h15A3C7E, "R4");
    for (int i = 0; i < 10; i++) apply(0, 0, 1, 25'h0, "R6");
    apply(0, 1, 0, 25'h0000F0F, "R3");
    for (int i = 0; i < 3; i++) apply(0, 0, 0, 25'h1, "R5");
    apply(0, 1, 1, 25'h1000000, "R4");
    apply(0, 0, 1, 25'h0, "R8");
    for (int i = 0; i < 400; i++) begin
      logic l, a;
      l = ($urandom % 12) == 0;
      a = ($urandom % 2) == 0;
      apply(0, l, a, l ? rnd_seed() : 25'h1, "R8");
    end
    apply(1, 0, 1, 25'h1, "R1");
    for (int i = 0; i < 150; i++) apply(0, 0, 1, 25'h1, "R9");
    @(negedge clk);
    adv = 0;
    @(posedge clk);
    #3;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule